// File: doc/BRIEF.md
# Watchdog Timer with Pre-Timeout Interrupt

This block is a watchdog peripheral with a 16-bit register interface. It counts down in half-second steps. Each step comes from a prescaler that divides a reference tick strobe. The reference tick is a one-cycle pulse at a 32.768 kHz rate, already synchronized to the system clock. Software arms the watchdog by setting the enable bit. It keeps the watchdog alive by writing a two-word service key. If the count runs out, the block pulses a reset request, latches the cause and restores its own control state.

A pre-timeout interrupt can be raised a programmable number of half-second steps before expiry. Counting can pause while the chip is in wait, debug or low-power mode, each under its own control bit. Software can also force a software reset or drive the external reset output directly. A timeout can additionally be routed to the external reset output.

Top module: `wdt_core`

## Requirements
- R1: After the reset input, reads return control 0x0030, cause 0x0010 (power-on flag in bit 4), interrupt control 0x0000 and misc 0x0000. The outputs are rst_req=0, ext_rst_n=1, irq=0 and pd_en=0.
- R2: Writing control (offset 0x00) with bit 2 set starts the countdown, with the period field in bits 15:8. rst_req then goes high for exactly one cycle after (period+1)×HALF_DIV active ref_tick pulses.
- R3: Once control bit 2 is set, a software write of 0 to it leaves it set until the next timeout, software reset or reset input.
- R4: Writing 0x5555 and then 0xAAAA to offset 0x02 restarts the full period and the prescaler. Any other word written there, or 0xAAAA without 0x5555 directly before it, cancels the sequence and does not reload.
- R5: Counting pauses while in_wait=1 and control bit 7 is set, while in_debug=1 and bit 1 is set, or while in_lowpwr=1 and bit 0 is set. A mode input whose control bit is clear does not pause counting.
- R6: Writing control with bit 4 clear pulses rst_req for one cycle in the next cycle. The cause register then reads 0x0001.
- R7: While control bit 5 is 0, ext_rst_n is 0. When control bit 3 is set, ext_rst_n is also 0 during the rst_req cycle caused by a timeout.
- R8: Interrupt control (offset 0x06) has enable in bit 15, flag in bit 14 and lead count in bits 7:0. The flag sets when the remaining count falls to the lead count, but only if bit 15 is set. Writing 1 to bit 14 clears the flag. irq = flag AND enable.
- R9: The cause register (offset 0x04) always has exactly one of bits 4, 1 and 0 set, naming the latest reset. A timeout gives 0x0002.
- R10: After a timeout or software reset, control, interrupt control and misc return to their reset values.
- R11: Bit 0 of misc (offset 0x08) is read/write and drives pd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ref_tick | input | 1 | One-cycle strobe at the 32.768 kHz reference rate |
| in_wait | input | 1 | Chip is in wait mode |
| in_debug | input | 1 | Chip is in debug mode |
| in_lowpwr | input | 1 | Chip is in low-power mode |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| rst_req | output | 1 | One-cycle reset request (timeout or software reset) |
| ext_rst_n | output | 1 | External reset output, active low |
| irq | output | 1 | Pre-timeout interrupt |
| pd_en | output | 1 | Power-down enable |

## Verification
The countdown is run with ref_tick held high, so the expiry cycle is exact and can be compared against (period+1)×HALF_DIV. The periods used are 0, 2, 3 and 5. Periodic valid key pairs, followed by a bad sequence (a lone second key, a broken pair), show whether a reload came from the full sequence alone. The measured remaining time after the bad sequence tells this apart. Each mode input is tried with and without its control bit, which separates a real pause from a pause leaking across modes. Interrupt runs with enable on and off show whether the flag depends on the enable.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int REG_W = 16;
    localparam int CNT_W = 8;

    localparam logic [3:0] OFS_CTRL  = 4'h0;
    localparam logic [3:0] OFS_SVC   = 4'h2;
    localparam logic [3:0] OFS_CAUSE = 4'h4;
    localparam logic [3:0] OFS_IRQC  = 4'h6;
    localparam logic [3:0] OFS_MISC  = 4'h8;

    localparam logic [REG_W-1:0] KEY_FIRST  = 16'h5555;
    localparam logic [REG_W-1:0] KEY_SECOND = 16'hAAAA;

    // control word, bit positions fixed by the register layout
    typedef struct packed {
        logic [CNT_W-1:0] period;    // 15:8
        logic             hold_wait; // 7
        logic             spare;     // 6
        logic             ext_quiet; // 5 : 0 drives external reset
        logic             sw_quiet;  // 4 : 0 requests software reset
        logic             tout_ext;  // 3
        logic             enable;    // 2
        logic             hold_dbg;  // 1
        logic             hold_lp;   // 0
    } ctrl_t;

    typedef struct packed {
        logic             ien;   // 15
        logic             flag;  // 14
        logic [5:0]       spare; // 13:8
        logic [CNT_W-1:0] lead;  // 7:0
    } irqc_t;

    typedef enum logic [2:0] {
        CAUSE_SOFT = 3'b001,
        CAUSE_TOUT = 3'b010,
        CAUSE_POR  = 3'b100
    } cause_e;

    typedef enum logic {
        KEY_IDLE,
        KEY_ARMED
    } key_state_e;

    function automatic ctrl_t ctrl_default();
        ctrl_t c;
        c = '0;
        c.ext_quiet = 1'b1;
        c.sw_quiet  = 1'b1;
        return c;
    endfunction

    function automatic logic [REG_W-1:0] cause_word(cause_e c);
        return {11'b0, c[2], 2'b00, c[1], c[0]};
    endfunction

    function automatic logic is_held(ctrl_t c, logic wt, logic dbg, logic lp);
        return (wt & c.hold_wait) | (dbg & c.hold_dbg) | (lp & c.hold_lp);
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int DIV = 16384
) (
    input  logic clk,
    input  logic clr,
    input  logic tick,
    input  logic run,
    output logic half_tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clr)
            cnt_q <= '0;
        else if (run && tick)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign half_tick = run && tick && (cnt_q == LAST);

    // R5: a paused prescaler keeps its phase
    AST_PRESCALE_HOLD: assert property (@(posedge clk) disable iff (clr)
        (!run) |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             clr,
    input  logic             wr_svc,
    input  logic [REG_W-1:0] wdata,
    output logic             reload
);
    key_state_e st_q;

    always_ff @(posedge clk) begin
        if (clr)
            st_q <= KEY_IDLE;
        else if (wr_svc)
            st_q <= (wdata == KEY_FIRST) ? KEY_ARMED : KEY_IDLE;
    end

    assign reload = wr_svc && (st_q == KEY_ARMED) && (wdata == KEY_SECOND);

    AST_KEY_RESTART: assert property (@(posedge clk) disable iff (clr)
        (wr_svc && wdata != KEY_FIRST) |=> (st_q == KEY_IDLE)); // R4
    AST_KEY_CONSUMED: assert property (@(posedge clk) disable iff (clr)
        reload |=> !reload); // R4
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] lead,
    input  logic             run,
    input  logic             half_tick,
    output logic             expire,
    output logic             lead_hit
);
    localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

    logic [CNT_W:0] rem_q;
    logic [CNT_W:0] rem_next;

    assign rem_next = rem_q - ONE;
    assign expire   = half_tick && (rem_q == ONE);
    assign lead_hit = half_tick && (rem_q > ONE) && (lead != '0)
                      && (rem_next == {1'b0, lead});

    always_ff @(posedge clk) begin
        if (clr)
            rem_q <= '0;
        else if (load)
            rem_q <= {1'b0, period} + ONE;
        else if (half_tick && rem_q != '0)
            rem_q <= rem_next;
    end

    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (clr)
        (!run && !load) |=> $stable(rem_q)); // R5
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int HALF_DIV = 16384
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic             in_wait,
    input  logic             in_debug,
    input  logic             in_lowpwr,
    input  logic [3:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             rst_req,
    output logic             ext_rst_n,
    output logic             irq,
    output logic             pd_en
);
    ctrl_t  ctrl_q;
    irqc_t  irqc_q;
    logic   misc_q;
    cause_e cause_q;
    logic   tout_q, soft_q;

    ctrl_t  wr_ctrl_val;
    irqc_t  wr_irqc_val;
    logic   wr_ctrl, wr_svc, wr_irqc, wr_misc;
    logic   reinit, sub_clr, run, load, reload, en_rise;
    logic   half_tick, expire, lead_hit, flag_set;

    assign wr_ctrl_val = ctrl_t'(bus_wdata);
    assign wr_irqc_val = irqc_t'(bus_wdata);
    assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_svc  = bus_wr && (bus_addr == OFS_SVC);
    assign wr_irqc = bus_wr && (bus_addr == OFS_IRQC);
    assign wr_misc = bus_wr && (bus_addr == OFS_MISC);

    assign reinit  = tout_q | soft_q;
    assign sub_clr = rst | reinit;
    assign run     = ctrl_q.enable && !is_held(ctrl_q, in_wait, in_debug, in_lowpwr);
    assign en_rise = wr_ctrl && !ctrl_q.enable && wr_ctrl_val.enable;
    assign load    = en_rise || (reload && ctrl_q.enable);
    assign flag_set = lead_hit && irqc_q.ien;

    wdt_prescaler #(.DIV(HALF_DIV)) u_pre (
        .clk       (clk),
        .clr       (sub_clr | load),
        .tick      (ref_tick),
        .run       (run),
        .half_tick (half_tick)
    );

    wdt_keyseq u_key (
        .clk    (clk),
        .clr    (sub_clr),
        .wr_svc (wr_svc),
        .wdata  (bus_wdata),
        .reload (reload)
    );

    wdt_countdown u_cnt (
        .clk       (clk),
        .clr       (sub_clr),
        .load      (load),
        .period    (en_rise ? wr_ctrl_val.period : ctrl_q.period),
        .lead      (irqc_q.lead),
        .run       (run),
        .half_tick (half_tick),
        .expire    (expire),
        .lead_hit  (lead_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= ctrl_default();
            irqc_q  <= '0;
            misc_q  <= 1'b0;
            cause_q <= CAUSE_POR;
            tout_q  <= 1'b0;
            soft_q  <= 1'b0;
        end else if (reinit) begin
            ctrl_q  <= ctrl_default();
            irqc_q  <= '0;
            misc_q  <= 1'b0;
            cause_q <= tout_q ? CAUSE_TOUT : CAUSE_SOFT;
            tout_q  <= 1'b0;
            soft_q  <= 1'b0;
        end else begin
            tout_q <= expire;
            soft_q <= wr_ctrl && !wr_ctrl_val.sw_quiet;
            if (wr_ctrl) begin
                ctrl_q        <= wr_ctrl_val;
                ctrl_q.spare  <= 1'b0;
                ctrl_q.enable <= ctrl_q.enable | wr_ctrl_val.enable;
            end
            if (wr_irqc) begin
                irqc_q.ien   <= wr_irqc_val.ien;
                irqc_q.lead  <= wr_irqc_val.lead;
                irqc_q.flag  <= (irqc_q.flag & ~wr_irqc_val.flag) | flag_set;
            end else if (flag_set) begin
                irqc_q.flag  <= 1'b1;
            end
            if (wr_misc)
                misc_q <= bus_wdata[0];
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_CTRL:  bus_rdata = ctrl_q;
            OFS_CAUSE: bus_rdata = cause_word(cause_q);
            OFS_IRQC:  bus_rdata = irqc_q;
            OFS_MISC:  bus_rdata = {15'b0, misc_q};
            default:   bus_rdata = '0;
        endcase
    end

    assign rst_req   = reinit;
    assign ext_rst_n = ctrl_q.ext_quiet && !(tout_q && ctrl_q.tout_ext);
    assign irq       = irqc_q.flag && irqc_q.ien;
    assign pd_en     = misc_q;

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req); // R2
    AST_ENABLE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.enable && !reinit) |=> ctrl_q.enable); // R3
    AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(cause_q) == 1); // R9
    AST_FLAG_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(irqc_q.flag) |-> $past(irqc_q.ien)); // R8
    AST_SOFT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (soft_q && !tout_q) |=> (cause_q == CAUSE_SOFT)); // R6
    AST_REINIT_CTRL: assert property (@(posedge clk) disable iff (rst)
        reinit |=> (ctrl_q == ctrl_default())); // R10
endmodule

// File: tb/sim_wdt_core.sv
module sim_wdt_core;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b1;
    logic        in_wait = 1'b0, in_debug = 1'b0, in_lowpwr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rst_req, ext_rst_n, irq, pd_en;

    int checks = 0;
    int fails  = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        rd_pending = 1'b0;

    always #10 clk = ~clk;

    wdt_core #(.HALF_DIV(N)) u0 (
        .clk(clk), .rst(rst), .ref_tick(ref_tick),
        .in_wait(in_wait), .in_debug(in_debug), .in_lowpwr(in_lowpwr),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rst_req(rst_req), .ext_rst_n(ext_rst_n),
        .irq(irq), .pd_en(pd_en)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, expv);
        end
    endtask

    // scoreboard monitor: pops expected read words
    always @(negedge clk) begin
        #2;
        if (rd_pending && exp_q.size() > 0) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(bus_rdata == e, t, bus_rdata, e);
        end
    end

    task automatic rd(input logic [3:0] a, input logic [15:0] e, input string t);
        @(negedge clk);
        bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd_pending = 1'b1;
        #5 rd_pending = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic wait_req(output int n);
        n = 0;
        while (n < 3000) begin
            @(negedge clk);
            n++;
            if (rst_req) break;
        end
    endtask

    task automatic quiet(input int n, input string t);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_req) seen++;
        end
        chk(seen == 0, t, seen, 0);
    endtask

    task automatic finish_tb();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_tb();
    end

    initial begin
        int n;
        int irq_seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(4'h0, 16'h0030, "R1 ctrl");
        rd(4'h4, 16'h0010, "R1 cause POR");
        rd(4'h6, 16'h0000, "R1 irqc");
        rd(4'h8, 16'h0000, "R1 misc");
        chk(!rst_req && ext_rst_n && !irq && !pd_en, "R1 outputs",
            {rst_req, ext_rst_n, irq, pd_en}, 4'b0100);

        // R2 timeout period 2 -> 3 halves
        wr(4'h0, 16'h0234);
        wait_req(n);
        chk(n >= 3*N-1 && n <= 3*N+1, "R2 timeout cycles", n, 3*N);
        @(negedge clk);
        chk(!rst_req, "R2 one-cycle pulse", rst_req, 0);
        rd(4'h4, 16'h0002, "R9 cause timeout");
        rd(4'h0, 16'h0030, "R10 ctrl restored");

        // R3 sticky enable, R4 servicing
        wr(4'h0, 16'h0334);
        wr(4'h0, 16'h0330);
        rd(4'h0, 16'h0334, "R3 enable stays set");
        for (int k = 0; k < 6; k++) begin
            quiet(6, "R4 serviced no reset");
            wr(4'h2, 16'h5555);
            wr(4'h2, 16'hAAAA);
        end
        wr(4'h2, 16'hAAAA);
        wr(4'h2, 16'h5555);
        wr(4'h2, 16'h1234);
        wr(4'h2, 16'hAAAA);
        wait_req(n);
        chk(n >= 4*N-5 && n <= 4*N-3, "R4 bad keys no reload", n, 4*N-4);
        rd(4'h4, 16'h0002, "R9 cause timeout again");

        // R6 software reset
        wr(4'h0, 16'h0020);
        @(negedge clk);
        chk(rst_req, "R6 soft request", rst_req, 1);
        @(negedge clk);
        chk(!rst_req, "R6 soft pulse ends", rst_req, 0);
        rd(4'h4, 16'h0001, "R6 cause soft");
        rd(4'h0, 16'h0030, "R10 ctrl after soft");

        // R7 external reset
        wr(4'h0, 16'h0010);
        @(negedge clk);
        chk(!ext_rst_n, "R7 ext asserted", ext_rst_n, 0);
        wr(4'h0, 16'h0030);
        @(negedge clk);
        chk(ext_rst_n, "R7 ext released", ext_rst_n, 1);
        wr(4'h0, 16'h003C);
        wait_req(n);
        chk(!ext_rst_n, "R7 timeout to ext", ext_rst_n, 0);
        @(negedge clk);
        chk(ext_rst_n, "R7 ext after timeout", ext_rst_n, 1);

        // R5 suspend modes
        in_debug = 1'b1; in_wait = 1'b1;
        wr(4'h0, 16'h0036);
        quiet(40, "R5 debug pause");
        @(negedge clk);
        in_debug = 1'b0;
        wait_req(n);
        chk(n >= N-1 && n <= N+1, "R5 wait ignored w/o bit7", n, N);
        in_wait = 1'b0; in_lowpwr = 1'b1;
        wr(4'h0, 16'h0034);
        wait_req(n);
        chk(n >= N-1 && n <= N+1, "R5 lowpwr ignored w/o bit0", n, N);
        wr(4'h0, 16'h0035);
        quiet(40, "R5 lowpwr pause");
        @(negedge clk);
        in_lowpwr = 1'b0;
        wait_req(n);
        chk(n >= N-1 && n <= N+1, "R5 lowpwr resume", n, N);
        in_wait = 1'b1;
        wr(4'h0, 16'h00B4);
        quiet(40, "R5 wait pause");
        @(negedge clk);
        in_wait = 1'b0;
        wait_req(n);
        chk(n >= N-1 && n <= N+1, "R5 wait resume", n, N);

        // R8 interrupt
        wr(4'h6, 16'h8002);
        wr(4'h0, 16'h0534);
        n = 0;
        while (n < 500 && !irq) begin
            @(negedge clk);
            n++;
        end
        chk(n >= 4*N-1 && n <= 4*N+1, "R8 irq lead time", n, 4*N);
        chk(!rst_req, "R8 irq before timeout", rst_req, 0);
        rd(4'h6, 16'hC002, "R8 flag set");
        wr(4'h6, 16'hC002);
        @(negedge clk);
        chk(!irq, "R8 flag cleared", irq, 0);
        rd(4'h6, 16'h8002, "R8 irqc after clear");
        wait_req(n);
        rd(4'h6, 16'h0000, "R10 irqc restored");
        wr(4'h6, 16'h0003);
        wr(4'h0, 16'h0334);
        irq_seen = 0;
        n = 0;
        while (n < 500 && !rst_req) begin
            @(negedge clk);
            n++;
            if (irq) irq_seen++;
        end
        chk(irq_seen == 0, "R8 masked no irq", irq_seen, 0);

        // R11 power-down enable
        wr(4'h8, 16'h0001);
        @(negedge clk);
        chk(pd_en, "R11 pd_en set", pd_en, 1);
        rd(4'h8, 16'h0001, "R11 misc readback");
        wr(4'h0, 16'h0020);
        repeat (2) @(negedge clk);
        chk(!pd_en, "R10 pd_en restored", pd_en, 0);

        repeat (3) @(negedge clk);
        finish_tb();
    end
endmodule